// File: doc/BRIEF.md
# Synthesizer Loop Core: Dividers and Phase/Frequency Detector

This block is a cycle-level digital model of the core of a phase-locked frequency synthesizer. A programmable main divider counts strobes from the RF input. A programmable reference divider counts strobes from the crystal input. Each strobe is a one-cycle enable in the block's clock domain. The divider outputs feed a three-state phase/frequency detector. The detector drives up/down enables for two charge pumps: a normal pump and a speed-up pump.

The speed-up pump is enabled by a FAST pin. That pin is sampled only while the detector is idle, so a correction pulse is never cut or extended part way through. A lock output reproduces each phase-error pulse, and a register bit can mask it. The block runs only when both the hardware power-on pin and the software power-on bit are high. While it is off, both dividers are held at their start value, so they restart in step when power returns. A ratio written while the block runs is taken only at that divider's terminal count.

Top module: `synth_loop_core`

## Requirements
- R1: The block is powered only when `pwrPin` and `swPowerOn` are both 1. While unpowered, `normPumpEn`, all four pump enables and `lockOut` are 0. While powered, `normPumpEn` is 1.
- R2: Each divider period is its programmed ratio in counted strobes. A main ratio below MAIN_MIN (512 by default) acts as MAIN_MIN. A reference ratio below REF_MIN (2 by default) acts as REF_MIN.
- R3: Leaving power-down, both dividers start from the same point. With a strobe every cycle, the first edge of a divider with effective ratio N comes N cycles after power-up. The first detector output appears in cycle min(N,R)+1 after power-up.
- R4: The detector raises up on a reference edge and down on a main edge. When both would be set, both clear, so up and down are never 1 together. Equal ratios give no pulse. On the first comparison, the pulse width is |N−R| cycles: up if the reference is faster, down otherwise.
- R5: `pumpNormUp` and `pumpNormDn` carry the detector state whenever the block is powered.
- R6: The speed-up pump enables equal the normal ones gated by a latch that copies `fastPin` only on clock edges after which the detector is idle. A change of `fastPin` during a pulse has no effect until that pulse ends.
- R7: `lockOut` is 1 exactly while either normal pump enable is 1, so its width equals the phase error.
- R8: With `lockMask` = 1, `lockOut` stays 0.
- R9: A ratio changed while powered takes effect only at the divider's next terminal count. The period in progress completes with the old ratio.
- R10: After reset, all outputs are 0 while the block is unpowered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfTick | input | 1 | Count strobe from the RF input |
| xtalTick | input | 1 | Count strobe from the crystal input |
| pwrPin | input | 1 | Hardware power-on |
| swPowerOn | input | 1 | Software power-on bit |
| fastPin | input | 1 | Speed-up request |
| lockMask | input | 1 | 1 masks the lock output |
| mainRatio | input | MAIN_W | Main divider ratio |
| refRatio | input | REF_W | Reference divider ratio |
| normPumpEn | output | 1 | Normal pump enabled (powered) |
| pumpNormUp | output | 1 | Normal pump up enable |
| pumpNormDn | output | 1 | Normal pump down enable |
| pumpFastUp | output | 1 | Speed-up pump up enable |
| pumpFastDn | output | 1 | Speed-up pump down enable |
| lockOut | output | 1 | Phase-error pulse for lock detection |

## Verification
The bench sweeps every pair of small main and reference ratios from power-up. For each pair it measures the first comparison's pulse direction, width and start cycle, which exposes a divider that skips its resynchronization or is off by one in its period. Further cases cover ratios below the minimum, where a design that skips the clamp gives the wrong pulse width. A ratio change during a count exposes a design that reloads at once and produces a pulse of the wrong width. A FAST drop in the middle of a pulse exposes a speed-up pump that truncates the correction. A power drop in the middle of a pulse must leave every output inactive.

// File: rtl/synth_loop_pkg.sv
package synth_loop_pkg;
  // Strobes from control to the divider datapath.
  typedef struct packed {
    logic run;     // dividers count when set
    logic preset;  // hold counters at their start value
  } divStrobe_t;
endpackage

// File: rtl/synth_div.sv
module synth_div
  import synth_loop_pkg::*;
#(
  parameter int W = 17,
  parameter int MIN_RATIO = 512
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  divStrobe_t   strobe,
  input  logic [W-1:0] ratio,
  output logic         edgeOut
);
  localparam logic [W-1:0] MinR = W'(MIN_RATIO);

  logic [W-1:0] cnt;
  logic [W-1:0] effRatio;
  logic [W-1:0] reloadVal;
  logic         terminal;

  // Clamp to the legal lower bound, then start value is ratio-1.
  assign effRatio  = (ratio < MinR) ? MinR : ratio;
  assign reloadVal = effRatio - W'(1);
  assign terminal  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= MinR - W'(1);
      edgeOut <= 1'b0;
    end else if (strobe.preset) begin
      cnt     <= reloadVal;
      edgeOut <= 1'b0;
    end else if (strobe.run && tick) begin
      // New ratio is read only here, at terminal count.
      cnt     <= terminal ? reloadVal : cnt - W'(1);
      edgeOut <= terminal;
    end else begin
      edgeOut <= 1'b0;
    end
  end
endmodule

// File: rtl/synth_datapath.sv
module synth_datapath
  import synth_loop_pkg::*;
#(
  parameter int MAIN_W = 17,
  parameter int MAIN_MIN = 512,
  parameter int REF_W = 14,
  parameter int REF_MIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rfTick,
  input  logic              xtalTick,
  input  divStrobe_t        strobe,
  input  logic [MAIN_W-1:0] mainRatio,
  input  logic [REF_W-1:0]  refRatio,
  output logic              mainEdge,
  output logic              refEdge
);
  synth_div #(.W(MAIN_W), .MIN_RATIO(MAIN_MIN)) u_mainDiv (
    .clk(clk), .rst_n(rst_n), .tick(rfTick), .strobe(strobe),
    .ratio(mainRatio), .edgeOut(mainEdge)
  );

  synth_div #(.W(REF_W), .MIN_RATIO(REF_MIN)) u_refDiv (
    .clk(clk), .rst_n(rst_n), .tick(xtalTick), .strobe(strobe),
    .ratio(refRatio), .edgeOut(refEdge)
  );
endmodule

// File: rtl/synth_control.sv
module synth_control
  import synth_loop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrPin,
  input  logic       swPowerOn,
  input  logic       fastPin,
  input  logic       lockMask,
  input  logic       mainEdge,
  input  logic       refEdge,
  output divStrobe_t strobe,
  output logic       normPumpEn,
  output logic       pumpNormUp,
  output logic       pumpNormDn,
  output logic       pumpFastUp,
  output logic       pumpFastDn,
  output logic       lockOut
);
  logic powered;
  logic upQ, dnQ, fastGate;
  logic upNext, dnNext;

  assign powered       = pwrPin & swPowerOn;
  assign strobe.run    = powered;
  assign strobe.preset = ~powered;

  assign upNext = upQ | refEdge;
  assign dnNext = dnQ | mainEdge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upQ      <= 1'b0;
      dnQ      <= 1'b0;
      fastGate <= 1'b0;
    end else if (!powered) begin
      upQ      <= 1'b0;
      dnQ      <= 1'b0;
      fastGate <= 1'b0;
    end else begin
      if (upNext && dnNext) begin
        upQ <= 1'b0;
        dnQ <= 1'b0;
      end else begin
        upQ <= upNext;
        dnQ <= dnNext;
      end
      // Detector idle after this edge: safe point to follow fastPin.
      if (upNext == dnNext) fastGate <= fastPin;
    end
  end

  assign normPumpEn = powered;
  assign pumpNormUp = upQ & powered;
  assign pumpNormDn = dnQ & powered;
  assign pumpFastUp = upQ & fastGate & powered;
  assign pumpFastDn = dnQ & fastGate & powered;
  assign lockOut    = (upQ | dnQ) & powered & ~lockMask;
endmodule

// File: rtl/synth_loop_core.sv
module synth_loop_core
  import synth_loop_pkg::*;
#(
  parameter int MAIN_W = 17,
  parameter int MAIN_MIN = 512,
  parameter int REF_W = 14,
  parameter int REF_MIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rfTick,
  input  logic              xtalTick,
  input  logic              pwrPin,
  input  logic              swPowerOn,
  input  logic              fastPin,
  input  logic              lockMask,
  input  logic [MAIN_W-1:0] mainRatio,
  input  logic [REF_W-1:0]  refRatio,
  output logic              normPumpEn,
  output logic              pumpNormUp,
  output logic              pumpNormDn,
  output logic              pumpFastUp,
  output logic              pumpFastDn,
  output logic              lockOut
);
  divStrobe_t strobe;
  logic mainEdge, refEdge;

  synth_datapath #(
    .MAIN_W(MAIN_W), .MAIN_MIN(MAIN_MIN), .REF_W(REF_W), .REF_MIN(REF_MIN)
  ) u_datapath (
    .clk(clk), .rst_n(rst_n), .rfTick(rfTick), .xtalTick(xtalTick),
    .strobe(strobe), .mainRatio(mainRatio), .refRatio(refRatio),
    .mainEdge(mainEdge), .refEdge(refEdge)
  );

  synth_control u_control (
    .clk(clk), .rst_n(rst_n), .pwrPin(pwrPin), .swPowerOn(swPowerOn),
    .fastPin(fastPin), .lockMask(lockMask), .mainEdge(mainEdge),
    .refEdge(refEdge), .strobe(strobe), .normPumpEn(normPumpEn),
    .pumpNormUp(pumpNormUp), .pumpNormDn(pumpNormDn),
    .pumpFastUp(pumpFastUp), .pumpFastDn(pumpFastDn), .lockOut(lockOut)
  );
endmodule

// File: rtl/synth_loop_core_chk.sv
module synth_loop_core_chk (
  input logic clk,
  input logic rst_n,
  input logic pwrPin,
  input logic swPowerOn,
  input logic lockMask,
  input logic normPumpEn,
  input logic pumpNormUp,
  input logic pumpNormDn,
  input logic pumpFastUp,
  input logic pumpFastDn,
  input logic lockOut
);
  logic on;
  assign on = pwrPin && swPowerOn;

  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!on && $past(!on)) |-> !(pumpNormUp || pumpNormDn || pumpFastUp || pumpFastDn || lockOut || normPumpEn));

  a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(pumpNormUp && pumpNormDn));

  a_r6_fast_up_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (pumpNormUp && $past(pumpNormUp)) |-> (pumpFastUp == $past(pumpFastUp)));

  a_r6_fast_dn_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (pumpNormDn && $past(pumpNormDn)) |-> (pumpFastDn == $past(pumpFastDn)));

  a_r6_fast_within_norm: assert property (@(posedge clk) disable iff (!rst_n)
    (pumpFastUp |-> pumpNormUp) and (pumpFastDn |-> pumpNormDn));

  a_r7_lock_tracks_error: assert property (@(posedge clk) disable iff (!rst_n)
    !lockMask |-> (lockOut == (pumpNormUp || pumpNormDn)));

  a_r8_lock_masked: assert property (@(posedge clk) disable iff (!rst_n)
    lockMask |-> !lockOut);
endmodule

bind synth_loop_core synth_loop_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwrPin(pwrPin), .swPowerOn(swPowerOn),
  .lockMask(lockMask), .normPumpEn(normPumpEn), .pumpNormUp(pumpNormUp),
  .pumpNormDn(pumpNormDn), .pumpFastUp(pumpFastUp), .pumpFastDn(pumpFastDn),
  .lockOut(lockOut)
);

// File: tb/synth_loop_core_bench.sv
module synth_loop_core_bench;
  localparam int MW = 5, RW = 5, MMIN = 4, RMIN = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, rfTick, xtalTick, pwrPin, swPowerOn, fastPin, lockMask;
  logic [MW-1:0] mainRatio;
  logic [RW-1:0] refRatio;
  logic normPumpEn, pumpNormUp, pumpNormDn, pumpFastUp, pumpFastDn, lockOut;

  int errors = 0, checks = 0;
  bit done = 0;

  synth_loop_core #(.MAIN_W(MW), .MAIN_MIN(MMIN), .REF_W(RW), .REF_MIN(RMIN))
  u_synth_loop_core (
    .clk(clk), .rst_n(rst_n), .rfTick(rfTick), .xtalTick(xtalTick),
    .pwrPin(pwrPin), .swPowerOn(swPowerOn), .fastPin(fastPin),
    .lockMask(lockMask), .mainRatio(mainRatio), .refRatio(refRatio),
    .normPumpEn(normPumpEn), .pumpNormUp(pumpNormUp), .pumpNormDn(pumpNormDn),
    .pumpFastUp(pumpFastUp), .pumpFastDn(pumpFastDn), .lockOut(lockOut)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // Power down, load settings, power up, sample win cycles.
  // chgKind: 0 none, 1 drop fastPin after sample chgAt, 2 set mainRatio=chgVal after chgAt
  task automatic measure(int n, int r, bit fastB, bit maskB, int win,
                         int chgKind, int chgAt, int chgVal,
                         output int upC, output int dnC, output int lkC,
                         output int fsC, output int first, output int enBad);
    swPowerOn = 1'b0;
    mainRatio = MW'(n);
    refRatio  = RW'(r);
    fastPin   = fastB;
    lockMask  = maskB;
    repeat (3) step();
    swPowerOn = 1'b1;
    upC = 0; dnC = 0; lkC = 0; fsC = 0; first = 0; enBad = 0;
    for (int s = 1; s <= win; s++) begin
      step();
      if (pumpNormUp) upC++;
      if (pumpNormDn) dnC++;
      if (lockOut) lkC++;
      if (pumpFastUp || pumpFastDn) fsC++;
      if (first == 0 && (pumpNormUp || pumpNormDn)) first = s;
      if (!normPumpEn) enBad++;
      if (s == chgAt && chgKind == 1) fastPin = 1'b0;
      if (s == chgAt && chgKind == 2) mainRatio = MW'(chgVal);
    end
  endtask

  initial begin
    int guard = 0;
    while (!done) begin
      @(posedge clk);
      guard++;
      if (guard > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int upC, dnC, lkC, fsC, first, enBad, d, mx, mn;
    rst_n = 1'b0; rfTick = 1'b1; xtalTick = 1'b1; pwrPin = 1'b1;
    swPowerOn = 1'b0; fastPin = 1'b0; lockMask = 1'b0;
    mainRatio = MW'(8); refRatio = RW'(8);
    repeat (3) step();
    // R10: reset state, unpowered
    check(!(pumpNormUp || pumpNormDn || pumpFastUp || pumpFastDn || lockOut || normPumpEn),
          "R10", "outputs in reset", 1, 0);
    rst_n = 1'b1;
    repeat (2) step();
    // R1: unpowered after reset
    check(!(pumpNormUp || pumpNormDn || lockOut || normPumpEn), "R1", "unpowered outputs", 1, 0);

    // R3 R4 R5 R6 R7 R8: sweep first comparison over all small ratio pairs
    for (int n = MMIN; n <= 12; n++) begin
      for (int r = RMIN; r <= 12; r++) begin
        bit fastB, maskB;
        fastB = ((n + r) % 2) == 1;
        maskB = ((n * r) % 3) == 0;
        mx = (n > r) ? n : r;
        mn = (n < r) ? n : r;
        d  = mx - mn;
        measure(n, r, fastB, maskB, mx + 1, 0, 0, 0, upC, dnC, lkC, fsC, first, enBad);
        check(upC == ((r < n) ? d : 0), "R4", "up width", upC, (r < n) ? d : 0);
        check(dnC == ((n < r) ? d : 0), "R4", "down width", dnC, (n < r) ? d : 0);
        check(lkC == (maskB ? 0 : d), "R7 R8", "lock width", lkC, maskB ? 0 : d);
        check(fsC == (fastB ? d : 0), "R6", "fast width", fsC, fastB ? d : 0);
        check(first == ((d == 0) ? 0 : mn + 1), "R3", "first pulse cycle", first, (d == 0) ? 0 : mn + 1);
        check(enBad == 0, "R1 R5", "normPumpEn low while powered", enBad, 0);
      end
    end

    // R2: ratios below minimum clamp (main 1 -> 4, ref 2)
    measure(1, 2, 1'b0, 1'b0, 5, 0, 0, 0, upC, dnC, lkC, fsC, first, enBad);
    check(upC == 2, "R2", "main clamp up width", upC, 2);
    measure(5, 0, 1'b0, 1'b0, 6, 0, 0, 0, upC, dnC, lkC, fsC, first, enBad);
    check(upC == 3, "R2", "ref clamp up width", upC, 3);

    // R6: fastPin dropped mid-pulse keeps full speed-up pulse
    measure(10, 4, 1'b1, 1'b0, 11, 1, 7, 0, upC, dnC, lkC, fsC, first, enBad);
    check(fsC == 6, "R6", "fast pulse kept after mid-pulse drop", fsC, 6);
    check(upC == 6, "R6", "normal pulse unaffected", upC, 6);

    // R9: main ratio 8 -> 6 written at cycle 3 applies at terminal count
    measure(8, 8, 1'b0, 1'b0, 17, 2, 3, 6, upC, dnC, lkC, fsC, first, enBad);
    check(dnC == 2, "R9", "down width after deferred update", dnC, 2);
    check(upC == 0, "R9", "no up pulse", upC, 0);
    check(first == 15, "R9", "first pulse cycle", first, 15);

    // R1: hardware pin drop mid-pulse silences everything
    measure(12, 4, 1'b1, 1'b0, 7, 0, 0, 0, upC, dnC, lkC, fsC, first, enBad);
    check(pumpNormUp == 1'b1, "R5", "pulse active before drop", int'(pumpNormUp), 1);
    pwrPin = 1'b0;
    #1;
    check(!(pumpNormUp || pumpFastUp || lockOut || normPumpEn), "R1", "outputs after pin drop", 1, 0);
    upC = 0;
    for (int s = 0; s < 20; s++) begin
      step();
      if (pumpNormUp || pumpNormDn || pumpFastUp || pumpFastDn || lockOut || normPumpEn) upC++;
    end
    check(upC == 0, "R1", "active samples while pin low", upC, 0);
    pwrPin = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule